// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block manages where incoming frame bytes land inside a packet memory that is divided into 256-byte pages. A contiguous span of pages, from a programmable first page up to (but not including) a programmable limit page, forms a circular receive area. The pages below the first page stay free for a separately managed transmit area. The block keeps a write pointer (the page where the next frame will start) and a read boundary (the oldest page the consumer has not yet released). It turns a byte stream into memory write strobes and addresses. When a frame completes, it moves the write pointer past the frame, wrapping from the limit back to the first page.

If a frame would run into the boundary page, the block refuses to commit the frame. It raises an overwrite status bit and ignores the stream until software acknowledges the condition. Software reads and programs the pointers through a small register window. A two-bit page field in a command register chooses between two register banks. The first bank holds the ring limits, the boundary, the status and the interrupt mask. The second bank holds the write pointer. An interrupt output combines the status bits with their mask bits.

Top module: `rxring_mgr`

## Requirements
- R1: After reset the first ring page reads 0x46, the limit page 0x80, the boundary 0x46, the write pointer 0x47, and status, mask and command all read 0x00; the interrupt output is low.
- R2: Command register bits [7:6] choose the register bank, and the command register (offset 0x0) is visible in every bank. Bank 0 (00) maps the first page at 0x1, the limit page at 0x2, the boundary at 0x3, status at 0x7 and the mask at 0xF. Bank 1 (01) maps the write pointer at 0x7. Unmapped offsets read 0x00.
- R3: While command bit 1 (run) is set, the k-th byte of a frame (k < 256) is written in the same cycle it is presented, at address {write pointer, k}, with the byte as write data.
- R4: After a frame fills offset 0xFF of a page, its next byte goes to offset 0x00 of the following page.
- R5: The page that follows limit-1 is the first ring page. Frames, and the write pointer, never use a page outside [first, limit).
- R6: One cycle after the last byte of a frame, the write pointer equals the page after the frame's last page, and status bit 0 is set.
- R7: If the page after the one being filled (at a page end or at the frame's last byte) equals the boundary, status bit 4 is set one cycle later. The write pointer keeps its value, and the rest of that frame is not written.
- R8: While status bit 4 is set, no byte is written and the write pointer does not move. A frame that begins while it is set is dropped to its end.
- R9: Writing the status register clears each bit written as 1 and leaves bits written as 0 unchanged.
- R10: The interrupt output is high exactly when some status bit and its mask bit are both set; mask 0x3F enables bits 0 to 5 and not bit 6.
- R11: With command bit 1 clear, the byte stream produces no writes and changes neither pointer nor status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset within the selected bank |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| rx_valid | input | 1 | A frame byte is presented this cycle |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Presented byte is the final byte of its frame |
| buf_we | output | 1 | Packet memory write strobe |
| buf_addr | output | 16 | Packet memory byte address {page, offset} |
| buf_wdata | output | 8 | Packet memory write data |
| irq | output | 1 | Interrupt request |

## Verification
The memory write strobe, address and data follow the presented byte in the same cycle. Pointer and status updates become visible one clock edge after the frame's last byte. The interrupt follows the status register in the same cycle, so it rises one edge after the event that sets a status bit. The bench therefore drives every input one nanosecond after a rising edge. It compares the write strobe and address for each byte at the falling edge of that same cycle. It reads the pointer and status through the register window only after the next rising edge has passed. Register reads are combinational, so a read value is sampled at the falling edge of the cycle in which its offset is driven.

// File: rtl/rxr_pkg.sv
// Shared constants for the paged receive ring manager: register offsets,
// bank codes and status bit positions.
package rxr_pkg;
    localparam int REG_AW = 4;

    // register bank selected by command bits [7:6]
    typedef enum logic [1:0] {
        BANK_MAIN = 2'b00,
        BANK_PTR  = 2'b01
    } reg_bank_e;

    localparam logic [REG_AW-1:0] OFS_CMD    = 4'h0;
    localparam logic [REG_AW-1:0] OFS_FIRST  = 4'h1;
    localparam logic [REG_AW-1:0] OFS_LIMIT  = 4'h2;
    localparam logic [REG_AW-1:0] OFS_BOUND  = 4'h3;
    localparam logic [REG_AW-1:0] OFS_STAT   = 4'h7;
    localparam logic [REG_AW-1:0] OFS_MASK   = 4'hF;
    localparam logic [REG_AW-1:0] OFS_WRPTR  = 4'h7;

    localparam int ST_FRAME_OK = 0;
    localparam int ST_OVERRUN  = 4;
    localparam int CMD_RUN     = 1;
endpackage

// File: rtl/rxr_regs.sv
// Register window of the ring manager.
// Holds command, ring limits, boundary and interrupt mask, decodes the bank
// select and drives the combinational read mux. The write pointer and the
// status bits live elsewhere; this module only forwards writes to them.
// Assumes register width equals the page number width.
module rxr_regs
    import rxr_pkg::*;
#(
    parameter int          PAGE_W      = 8,
    parameter logic [PAGE_W-1:0] FIRST_RST = 8'h46,
    parameter logic [PAGE_W-1:0] LIMIT_RST = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [PAGE_W-1:0] reg_wdata,
    output logic [PAGE_W-1:0] reg_rdata,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [PAGE_W-1:0] stat,
    output logic [PAGE_W-1:0] ring_first,
    output logic [PAGE_W-1:0] ring_limit,
    output logic [PAGE_W-1:0] bound_page,
    output logic [PAGE_W-1:0] irq_mask,
    output logic              run,
    output logic              wptr_load,
    output logic [PAGE_W-1:0] wptr_value,
    output logic [PAGE_W-1:0] stat_clr
);
    logic [PAGE_W-1:0] cmd_q;
    reg_bank_e         bank;
    logic              in_main;
    logic              in_ptr;

    assign bank    = reg_bank_e'(cmd_q[PAGE_W-1:PAGE_W-2]);
    assign in_main = (bank == BANK_MAIN);
    assign in_ptr  = (bank == BANK_PTR);
    assign run     = cmd_q[CMD_RUN];

    // strobes for state kept in other modules
    assign wptr_load  = reg_we && in_ptr && (reg_addr == OFS_WRPTR);
    assign wptr_value = reg_wdata;
    assign stat_clr   = (reg_we && in_main && (reg_addr == OFS_STAT)) ? reg_wdata : '0;

    // register storage with bank-qualified write decode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q      <= '0;
            ring_first <= FIRST_RST;
            ring_limit <= LIMIT_RST;
            bound_page <= FIRST_RST;
            irq_mask   <= '0;
        end else if (reg_we) begin
            if (reg_addr == OFS_CMD) begin
                cmd_q <= reg_wdata;
            end else if (in_main) begin
                case (reg_addr)
                    OFS_FIRST: ring_first <= reg_wdata;
                    OFS_LIMIT: ring_limit <= reg_wdata;
                    OFS_BOUND: bound_page <= reg_wdata;
                    OFS_MASK:  irq_mask   <= reg_wdata;
                    default:   ;
                endcase
            end
        end
    end

    // read mux: command everywhere, the rest by bank
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_CMD) begin
            reg_rdata = cmd_q;
        end else if (in_main) begin
            case (reg_addr)
                OFS_FIRST: reg_rdata = ring_first;
                OFS_LIMIT: reg_rdata = ring_limit;
                OFS_BOUND: reg_rdata = bound_page;
                OFS_STAT:  reg_rdata = stat;
                OFS_MASK:  reg_rdata = irq_mask;
                default:   reg_rdata = '0;
            endcase
        end else if (in_ptr && (reg_addr == OFS_WRPTR)) begin
            reg_rdata = wr_page;
        end
    end
endmodule

// File: rtl/rxr_walker.sv
// Page walker: places each accepted byte at {page, offset}, steps to the next
// ring page when a page fills, commits the write pointer at frame end and
// reports completion or a collision with the boundary page.
// Assumes ring_first < ring_limit and that software keeps the pointers
// inside the ring. A completed frame takes priority over a software load of
// the write pointer in the same cycle.
module rxr_walker #(
    parameter int          PAGE_W   = 8,
    parameter int          OFF_W    = 8,
    parameter logic [PAGE_W-1:0] WPTR_RST = 8'h47,
    localparam int         ADDR_W   = PAGE_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              halted,
    input  logic [PAGE_W-1:0] ring_first,
    input  logic [PAGE_W-1:0] ring_limit,
    input  logic [PAGE_W-1:0] bound_page,
    input  logic              wptr_load,
    input  logic [PAGE_W-1:0] wptr_value,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    output logic [PAGE_W-1:0] wr_page,
    output logic              frame_done,
    output logic              overrun
);
    logic              active_q;
    logic              drop_q;
    logic [PAGE_W-1:0] fill_page_q;
    logic [OFF_W-1:0]  fill_off_q;
    logic [PAGE_W-1:0] wptr_q;

    logic [PAGE_W-1:0] cur_page;
    logic [OFF_W-1:0]  cur_off;
    logic [PAGE_W-1:0] page_inc;
    logic [PAGE_W-1:0] next_page;
    logic              accept;
    logic              page_full;
    logic              collide;

    assign cur_page  = active_q ? fill_page_q : wptr_q;
    assign cur_off   = active_q ? fill_off_q  : '0;
    assign page_inc  = cur_page + 1'b1;
    assign next_page = (page_inc == ring_limit) ? ring_first : page_inc;
    assign accept    = rx_valid && run && !halted && !drop_q;
    assign page_full = (cur_off == {OFF_W{1'b1}});
    assign collide   = (next_page == bound_page);

    assign buf_we     = accept;
    assign buf_addr   = {cur_page, cur_off};
    assign buf_wdata  = rx_data;
    assign wr_page    = wptr_q;
    assign frame_done = accept && rx_last && !collide;
    assign overrun    = accept && collide && (rx_last || page_full);

    // in-frame position and drop tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q    <= 1'b0;
            drop_q      <= 1'b0;
            fill_page_q <= '0;
            fill_off_q  <= '0;
        end else if (rx_valid && rx_last) begin
            active_q <= 1'b0;
            drop_q   <= 1'b0;
        end else if (accept) begin
            if (page_full && collide) begin
                active_q <= 1'b0;
                drop_q   <= 1'b1;
            end else if (page_full) begin
                active_q    <= 1'b1;
                fill_page_q <= next_page;
                fill_off_q  <= '0;
            end else begin
                active_q    <= 1'b1;
                fill_page_q <= cur_page;
                fill_off_q  <= cur_off + 1'b1;
            end
        end else if (rx_valid) begin
            active_q <= 1'b0;
            drop_q   <= 1'b1;
        end
    end

    // write pointer: frame commit first, then software load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= WPTR_RST;
        end else if (frame_done) begin
            wptr_q <= next_page;
        end else if (wptr_load) begin
            wptr_q <= wptr_value;
        end
    end
endmodule

// File: rtl/rxr_irq.sv
// Status bits with write-one-to-clear and the masked interrupt output.
// Only the frame-complete and overrun bits have set sources; the others
// stay zero. A set and a clear of the same bit in one cycle leave it set.
module rxr_irq
    import rxr_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic              overrun,
    input  logic [STAT_W-1:0] stat_clr,
    input  logic [STAT_W-1:0] irq_mask,
    output logic [STAT_W-1:0] stat,
    output logic              irq
);
    logic [STAT_W-1:0] set_vec;

    // gather set sources into their bit positions
    always_comb begin
        set_vec              = '0;
        set_vec[ST_FRAME_OK] = frame_done;
        set_vec[ST_OVERRUN]  = overrun;
    end

    // per-bit sticky status
    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat[b] <= 1'b0;
            end else if (set_vec[b]) begin
                stat[b] <= 1'b1;
            end else if (stat_clr[b]) begin
                stat[b] <= 1'b0;
            end
        end
    end

    assign irq = |(stat & irq_mask);
endmodule

// File: rtl/rxring_mgr.sv
// Top of the paged receive ring manager: register window, page walker and
// interrupt logic. The byte stream is accepted without back-pressure; the
// packet memory is assumed to take one byte write per cycle.
module rxring_mgr
    import rxr_pkg::*;
#(
    parameter int          PAGE_W    = 8,
    parameter int          OFF_W     = 8,
    parameter logic [PAGE_W-1:0] FIRST_RST = 8'h46,
    parameter logic [PAGE_W-1:0] LIMIT_RST = 8'h80,
    localparam int         ADDR_W    = PAGE_W + OFF_W,
    localparam logic [PAGE_W-1:0] WPTR_RST = FIRST_RST + 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [PAGE_W-1:0] reg_wdata,
    output logic [PAGE_W-1:0] reg_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    output logic              irq
);
    logic [PAGE_W-1:0] ring_first;
    logic [PAGE_W-1:0] ring_limit;
    logic [PAGE_W-1:0] bound_page;
    logic [PAGE_W-1:0] irq_mask;
    logic [PAGE_W-1:0] stat;
    logic [PAGE_W-1:0] stat_clr;
    logic [PAGE_W-1:0] wr_page;
    logic [PAGE_W-1:0] wptr_value;
    logic              run;
    logic              wptr_load;
    logic              frame_done;
    logic              overrun;

    rxr_regs #(
        .PAGE_W    (PAGE_W),
        .FIRST_RST (FIRST_RST),
        .LIMIT_RST (LIMIT_RST)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .wr_page    (wr_page),
        .stat       (stat),
        .ring_first (ring_first),
        .ring_limit (ring_limit),
        .bound_page (bound_page),
        .irq_mask   (irq_mask),
        .run        (run),
        .wptr_load  (wptr_load),
        .wptr_value (wptr_value),
        .stat_clr   (stat_clr)
    );

    rxr_walker #(
        .PAGE_W   (PAGE_W),
        .OFF_W    (OFF_W),
        .WPTR_RST (WPTR_RST)
    ) walk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .halted     (stat[ST_OVERRUN]),
        .ring_first (ring_first),
        .ring_limit (ring_limit),
        .bound_page (bound_page),
        .wptr_load  (wptr_load),
        .wptr_value (wptr_value),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_last    (rx_last),
        .buf_we     (buf_we),
        .buf_addr   (buf_addr),
        .buf_wdata  (buf_wdata),
        .wr_page    (wr_page),
        .frame_done (frame_done),
        .overrun    (overrun)
    );

    rxr_irq #(
        .STAT_W (PAGE_W)
    ) irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .overrun    (overrun),
        .stat_clr   (stat_clr),
        .irq_mask   (irq_mask),
        .stat       (stat),
        .irq        (irq)
    );
endmodule

// File: rtl/rxring_mgr_chk.sv
// Temporal checks on the ring manager, attached to every instance by bind.
module rxring_mgr_chk #(
    parameter int PAGE_W = 8,
    parameter int OFF_W  = 8,
    localparam int ADDR_W = PAGE_W + OFF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              buf_we,
    input logic [ADDR_W-1:0] buf_addr,
    input logic [PAGE_W-1:0] ring_first,
    input logic [PAGE_W-1:0] ring_limit,
    input logic [PAGE_W-1:0] bound_page,
    input logic [PAGE_W-1:0] wr_page,
    input logic [PAGE_W-1:0] stat,
    input logic              wptr_load
);
    logic [PAGE_W-1:0] wpage;
    assign wpage = buf_addr[ADDR_W-1:OFF_W];

    // R5
    ring_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (wpage >= ring_first) && (wpage < ring_limit));

    // R7
    no_bound_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (wpage != bound_page));

    // R7
    overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[4]) |-> $stable(wr_page));

    // R8
    halted_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat[4] |-> !buf_we);

    // R6
    commit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(wr_page) && !$past(wptr_load)) |-> stat[0]);
endmodule

bind rxring_mgr rxring_mgr_chk #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .buf_we     (buf_we),
    .buf_addr   (buf_addr),
    .ring_first (ring_first),
    .ring_limit (ring_limit),
    .bound_page (bound_page),
    .wr_page    (wr_page),
    .stat       (stat),
    .wptr_load  (wptr_load)
);

// File: tb/rxring_mgr_tb_top.sv
module rxring_mgr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        buf_we;
    logic [15:0] buf_addr;
    logic [7:0]  buf_wdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // model of the programmed ring, kept by the bench
    logic [7:0] m_first = 8'h46;
    logic [7:0] m_limit = 8'h80;
    logic [7:0] m_bound = 8'h46;
    logic [7:0] m_wptr  = 8'h47;

    always #5 clk = ~clk;

    rxring_mgr dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .irq(irq)
    );

    typedef struct packed {
        logic [15:0] len;
        logic [7:0]  bound;
        logic [7:0]  exp_wptr;
        logic        exp_ovr;
    } vec_t;

    // ring 0x46..0x49 (limit 0x4A)
    localparam vec_t VT [7] = '{
        '{16'd10,  8'h46, 8'h48, 1'b0},
        '{16'd256, 8'h46, 8'h49, 1'b0},
        '{16'd1,   8'h46, 8'h49, 1'b1},
        '{16'd1,   8'h48, 8'h46, 1'b0},
        '{16'd300, 8'h48, 8'h46, 1'b1},
        '{16'd300, 8'h49, 8'h48, 1'b0},
        '{16'd300, 8'h49, 8'h48, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    function automatic logic [7:0] step(input logic [7:0] p);
        logic [7:0] q;
        q = p + 8'd1;
        return (q == m_limit) ? m_first : q;
    endfunction

    // Sends one frame; checks every byte's strobe and address against the
    // ring model. silent=1 means no byte may be written (R8/R11).
    task automatic send(input int len, input bit silent, input string req,
                        output logic [7:0] ewptr, output bit eovr);
        logic [7:0] p;
        logic [7:0] o;
        bit dropping;
        int miss;
        p = m_wptr; o = 8'h00; dropping = silent; miss = 0; eovr = 1'b0;
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            rx_valid = 1'b1; rx_data = 8'(i * 7 + 3); rx_last = (i == len - 1);
            @(negedge clk);
            if (dropping) begin
                if (buf_we) miss++;
            end else begin
                if (!buf_we || buf_addr != {p, o} || buf_wdata != 8'(i * 7 + 3)) miss++;
                if (i != len - 1 && o == 8'hFF) begin
                    if (step(p) == m_bound) begin dropping = 1'b1; eovr = 1'b1; end
                    else begin p = step(p); o = 8'h00; end
                end else begin
                    o = o + 8'd1;
                end
            end
        end
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_last = 1'b0;
        ewptr = m_wptr;
        if (!silent && !eovr) begin
            if (step(p) == m_bound) eovr = 1'b1;
            else ewptr = step(p);
        end
        chk(miss == 0, req, miss, 0);
    endtask

    logic [7:0] v;
    logic [7:0] ew;
    bit eo;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        rd(4'h1, v); chk(v == 8'h46, "R1 first page", v, 8'h46);
        rd(4'h2, v); chk(v == 8'h80, "R1 limit page", v, 8'h80);
        rd(4'h3, v); chk(v == 8'h46, "R1 boundary", v, 8'h46);
        rd(4'h7, v); chk(v == 8'h00, "R1 status", v, 8'h00);
        rd(4'hF, v); chk(v == 8'h00, "R1 mask", v, 8'h00);
        rd(4'h0, v); chk(v == 8'h00, "R1 command", v, 8'h00);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        wr(4'h0, 8'h40);
        rd(4'h7, v); chk(v == 8'h47, "R1 R2 write pointer in bank 1", v, 8'h47);
        rd(4'h1, v); chk(v == 8'h00, "R2 unmapped in bank 1", v, 8'h00);
        rd(4'h0, v); chk(v == 8'h40, "R2 command in bank 1", v, 8'h40);

        // R11 stream ignored while run is clear
        wr(4'h0, 8'h00);
        send(4, 1'b1, "R11 no writes with run clear", ew, eo);
        rd(4'h7, v); chk(v == 8'h00, "R11 status unchanged", v, 8'h00);

        // shrink the ring to 0x46..0x49 and start
        wr(4'h2, 8'h4A); m_limit = 8'h4A;
        wr(4'h0, 8'h02);

        // table walk: R3 R4 R5 R6 R7
        foreach (VT[k]) begin
            wr(4'h3, VT[k].bound); m_bound = VT[k].bound;
            wr(4'h7, 8'hFF);
            send(int'(VT[k].len), 1'b0, "R3 R4 R5 byte placement", ew, eo);
            chk(ew == VT[k].exp_wptr && eo == VT[k].exp_ovr, "R5 R7 bench model", ew, VT[k].exp_wptr);
            rd(4'h7, v);
            chk(v == (VT[k].exp_ovr ? 8'h10 : 8'h01), "R6 R7 status after frame", v,
                VT[k].exp_ovr ? 8'h10 : 8'h01);
            wr(4'h0, 8'h42);
            rd(4'h7, v); chk(v == VT[k].exp_wptr, "R6 R7 write pointer after frame", v, VT[k].exp_wptr);
            wr(4'h0, 8'h02);
            m_wptr = VT[k].exp_wptr;
        end

        // R9 writing zero bits leaves status alone
        wr(4'h7, 8'h01);
        rd(4'h7, v); chk(v == 8'h10, "R9 zero bits keep status", v, 8'h10);

        // R8 halted: frame dropped while overrun is pending
        wr(4'h3, 8'h46); m_bound = 8'h46;
        send(5, 1'b1, "R8 no writes while halted", ew, eo);
        wr(4'h0, 8'h42);
        rd(4'h7, v); chk(v == 8'h48, "R8 write pointer held", v, 8'h48);
        wr(4'h0, 8'h02);

        // R9 clear, then reception resumes
        wr(4'h7, 8'h10);
        rd(4'h7, v); chk(v == 8'h00, "R9 one bit clears", v, 8'h00);
        send(5, 1'b0, "R8 resume after clear", ew, eo);
        chk(ew == 8'h49 && !eo, "R8 resume model", ew, 8'h49);
        rd(4'h7, v); chk(v == 8'h01, "R6 frame flag after resume", v, 8'h01);
        m_wptr = 8'h49;

        // R10 masking (status now 0x01)
        @(negedge clk); chk(irq == 1'b0, "R10 mask zero", irq, 0);
        wr(4'hF, 8'h3F);
        @(negedge clk); chk(irq == 1'b1, "R10 mask 0x3F", irq, 1);
        wr(4'hF, 8'h40);
        @(negedge clk); chk(irq == 1'b0, "R10 bit 6 only", irq, 0);
        wr(4'hF, 8'h10);
        @(negedge clk); chk(irq == 1'b0, "R10 overrun bit only", irq, 0);
        wr(4'hF, 8'h01);
        @(negedge clk); chk(irq == 1'b1, "R10 frame bit", irq, 1);
        wr(4'h7, 8'h01);
        @(negedge clk); chk(irq == 1'b0, "R9 R10 irq drops after clear", irq, 0);

        // R2 software load of the write pointer through bank 1
        wr(4'h0, 8'h42);
        wr(4'h7, 8'h47);
        rd(4'h7, v); chk(v == 8'h47, "R2 write pointer load", v, 8'h47);
        wr(4'h0, 8'h02);
        rd(4'h7, v); chk(v == 8'h00, "R2 bank 0 status not pointer", v, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule